// File: doc/BRIEF.md
# Bus Interrupt Level Selector with Acknowledge Sequencer

This block sits between a backplane's seven active-low interrupt request lines and a host processor. A 3-bit level code from the control register chooses which single request line is watched; code zero watches nothing. The chosen line, once brought into the local clock domain, appears as a status flag. It reaches the host interrupt output when interrupts are enabled. A software interrupt bit, and optionally a bus-error flag, can also raise the host interrupt.

When the host reads the vector location, the block asks the bus master for an interrupt-acknowledge cycle at the level held in the control register. The level is driven on address bits 3:1 during that cycle. The block holds the request until the master reports the cycle done, then stores the returned vector: all 16 bits for a wide host read, or only the low byte, zero-extended, for a narrow one. With level code zero no cycle is requested and the vector reads as zero.

Top module: `irq_vector_unit`

## Requirements
- R1: After a synchronous active-low reset, host_int, ack_req and rd_done are 0, ack_addr is 0 and vec_out is 0.
- R2: Level code k in 1..7 on lvl_sel watches irq_n[k-1] (low means active), and line_active follows that line alone. Code 0 watches no line and keeps line_active at 0.
- R3: Each request line passes through two flip-flops. A change on the selected line shows on line_active after the second rising clock edge, not after the first.
- R4: host_int is registered. One edge after its inputs change it equals (int_en AND line_active) OR soft_int OR (berr_int_en AND berr_flag).
- R5: soft_int set forces host_int to 1 one edge later, with int_en at 0 and no line active.
- R6: berr_flag raises host_int only while berr_int_en is 1. With berr_int_en at 0 it has no effect.
- R7: A vec_rd pulse with a nonzero level code raises ack_req one edge later. ack_addr equals that level code, and both hold until the edge where ack_done is sampled high.
- R8: ack_wide during the cycle equals vec_wide at the time of the read. A wide read stores ack_data[15:0] in vec_out. A narrow read stores ack_data[7:0] with bits 15:8 cleared.
- R9: A vec_rd pulse with level code 0 starts no acknowledge cycle. vec_out becomes 0 and rd_done pulses one edge later.
- R10: While a cycle is pending, changes on lvl_sel and further vec_rd pulses are ignored. ack_addr keeps the latched level, and only one rd_done follows.
- R11: rd_done is a single-cycle pulse in the cycle after the vector is stored, and vec_out holds its value until the next completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_n | input | 7 | Backplane request lines, bit k-1 is level k, active low |
| lvl_sel | input | 3 | Control register level code, 0 = none |
| int_en | input | 1 | Control register interrupt enable |
| soft_int | input | 1 | Control register software interrupt |
| berr_flag | input | 1 | Bus-error flag from the cycle engine |
| berr_int_en | input | 1 | Configuration: bus error also interrupts the host |
| vec_rd | input | 1 | One-cycle pulse: host read of the vector location |
| vec_wide | input | 1 | 1 = 16-bit host read, 0 = 8-bit |
| ack_done | input | 1 | Acknowledge cycle finished, ack_data valid |
| ack_data | input | 16 | Vector returned by the interrupting slave |
| host_int | output | 1 | Interrupt to the host |
| line_active | output | 1 | Status: the watched line is asserted |
| ack_req | output | 1 | Request for an interrupt-acknowledge cycle |
| ack_addr | output | 3 | Level driven on address bits 3:1 |
| ack_wide | output | 1 | Acknowledge cycle asks for 16 bits |
| vec_out | output | 16 | Captured vector register |
| rd_done | output | 1 | Read of the vector location has completed |

## Verification
Selection is driven with one line active at a time and with every line active, under each level code, which separates a correct decode from one that ORs lines together or is off by one level. Host interrupt sources are switched on singly, so each gate term is seen alone. Acknowledge reads mix wide and narrow widths with data whose high and low bytes differ, plus a read at level zero. Lvl_sel is changed and vec_rd pulsed during a pending cycle, which shows whether the level is latched and whether extra reads are dropped.

// File: rtl/irqsel_pkg.sv
// Shared constants and types for the interrupt level selector.
package irqsel_pkg;
    localparam int NUM_LVL = 7;
    localparam int LVL_W   = 3;
    localparam int VEC_W   = 16;

    typedef enum logic [0:0] {
        ACK_IDLE = 1'b0,
        ACK_WAIT = 1'b1
    } ack_state_t;
endpackage

// File: rtl/irq_sync.sv
// Two-stage synchronizer for a vector of active-low request lines.
// Assumes the lines are asynchronous to clk. Output is active high.
module irq_sync #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_n,
    output logic [N-1:0] req_act
);
    logic [N-1:0] stg1_n;
    logic [N-1:0] stg2_n;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Two flops per line; reset to the inactive (high) level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg1_n[i] <= 1'b1;
                stg2_n[i] <= 1'b1;
            end else begin
                stg1_n[i] <= req_n[i];
                stg2_n[i] <= stg1_n[i];
            end
        end
        assign req_act[i] = ~stg2_n[i];
    end
endmodule

// File: rtl/irq_level_pick.sv
// Selects one active-high request by level code. Code k (1..N) picks
// bit k-1; code 0 picks nothing. Purely combinational.
module irq_level_pick #(
    parameter int N = 7,
    parameter int W = 3
) (
    input  logic [N-1:0] act,
    input  logic [W-1:0] lvl,
    output logic         hit
);
    logic [N-1:0] match;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = act[i] && (lvl == W'(i + 1));
    end

    // Any matching line means the selected level is active.
    always_comb hit = |match;
endmodule

// File: rtl/irq_host_gate.sv
// Combines the watched line, the software interrupt and the optional
// bus-error source into a registered host interrupt.
module irq_host_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic int_en,
    input  logic soft_int,
    input  logic berr_flag,
    input  logic berr_int_en,
    output logic host_int
);
    logic int_d;

    // Next value of the host interrupt from the three sources.
    always_comb int_d = (int_en && hit) || soft_int || (berr_int_en && berr_flag);

    // Register the result so the output never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) host_int <= 1'b0;
        else        host_int <= int_d;
    end

    // R5
    soft_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_int |=> host_int);

    // R6
    berr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_int && !int_en && !berr_int_en) |=> !host_int);
endmodule

// File: rtl/ack_seq.sv
// Interrupt-acknowledge sequencer. A host read of the vector location
// either completes at once (level 0) or requests a bus cycle at the
// latched level and waits for ack_done, then stores the vector.
// Assumes vec_rd is a single-cycle pulse and ack_done only comes while
// a request is pending.
module ack_seq
    import irqsel_pkg::*;
#(
    parameter int W  = LVL_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  lvl,
    input  logic          vec_rd,
    input  logic          vec_wide,
    input  logic          ack_done,
    input  logic [VW-1:0] ack_data,
    output logic          ack_req,
    output logic [W-1:0]  ack_addr,
    output logic          ack_wide,
    output logic [VW-1:0] vec_out,
    output logic          rd_done
);
    localparam int HI_W = VW - 8;

    ack_state_t    state;
    logic [W-1:0]  lvl_q;
    logic          wide_q;
    logic [VW-1:0] vec_q;
    logic          done_q;
    logic [VW-1:0] cap_val;

    // Width-dependent view of the returned vector.
    always_comb cap_val = wide_q ? ack_data : {{HI_W{1'b0}}, ack_data[7:0]};

    // Sequencer: accept a read, wait for the bus cycle, store the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ACK_IDLE;
            lvl_q  <= '0;
            wide_q <= 1'b0;
            vec_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ACK_IDLE: begin
                    if (vec_rd) begin
                        if (lvl == '0) begin
                            vec_q  <= '0;
                            done_q <= 1'b1;
                        end else begin
                            lvl_q  <= lvl;
                            wide_q <= vec_wide;
                            state  <= ACK_WAIT;
                        end
                    end
                end
                ACK_WAIT: begin
                    if (ack_done) begin
                        vec_q  <= cap_val;
                        done_q <= 1'b1;
                        state  <= ACK_IDLE;
                    end
                end
                default: state <= ACK_IDLE;
            endcase
        end
    end

    assign ack_req  = (state == ACK_WAIT);
    assign ack_addr = ack_req ? lvl_q : '0;
    assign ack_wide = ack_req && wide_q;
    assign vec_out  = vec_q;
    assign rd_done  = done_q;

    // R7
    ack_level_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> (ack_addr != '0));

    // R10
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack_done) |=> (ack_req && $stable(ack_addr) && $stable(ack_wide)));

    // R9
    zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !ack_req && lvl == '0) |=> (!ack_req && rd_done && vec_out == '0));

    // R8
    narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack_wide && ack_done) |=> (vec_out[VW-1:8] == '0));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (!rd_done && $stable(vec_out)));
endmodule

// File: rtl/irq_vector_unit.sv
// Top level: synchronizes the request lines, picks one by level code,
// drives the host interrupt and runs the acknowledge sequencer.
// Assumes control inputs are already in the clk domain.
module irq_vector_unit
    import irqsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] irq_n,
    input  logic [LVL_W-1:0]   lvl_sel,
    input  logic               int_en,
    input  logic               soft_int,
    input  logic               berr_flag,
    input  logic               berr_int_en,
    input  logic               vec_rd,
    input  logic               vec_wide,
    input  logic               ack_done,
    input  logic [VEC_W-1:0]   ack_data,
    output logic               host_int,
    output logic               line_active,
    output logic               ack_req,
    output logic [LVL_W-1:0]   ack_addr,
    output logic               ack_wide,
    output logic [VEC_W-1:0]   vec_out,
    output logic               rd_done
);
    logic [NUM_LVL-1:0] req_act;

    irq_sync #(.N(NUM_LVL)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n   (irq_n),
        .req_act (req_act)
    );

    irq_level_pick #(.N(NUM_LVL), .W(LVL_W)) u_pick (
        .act (req_act),
        .lvl (lvl_sel),
        .hit (line_active)
    );

    irq_host_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (line_active),
        .int_en      (int_en),
        .soft_int    (soft_int),
        .berr_flag   (berr_flag),
        .berr_int_en (berr_int_en),
        .host_int    (host_int)
    );

    ack_seq #(.W(LVL_W), .VW(VEC_W)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_sel),
        .vec_rd   (vec_rd),
        .vec_wide (vec_wide),
        .ack_done (ack_done),
        .ack_data (ack_data),
        .ack_req  (ack_req),
        .ack_addr (ack_addr),
        .ack_wide (ack_wide),
        .vec_out  (vec_out),
        .rd_done  (rd_done)
    );

    // R2
    none_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_sel == '0) |-> !line_active);

    // R4
    enabled_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en && line_active) |=> host_int);
endmodule

// File: tb/irq_vector_unit_test.sv
module irq_vector_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  irq_n;
    logic [2:0]  lvl_sel;
    logic        int_en, soft_int, berr_flag, berr_int_en;
    logic        vec_rd, vec_wide, ack_done;
    logic [15:0] ack_data;
    logic        host_int, line_active, ack_req, ack_wide, rd_done;
    logic [2:0]  ack_addr;
    logic [15:0] vec_out;

    int checks = 0;
    int bad    = 0;
    int cycles = 0;
    int done_seen = 0;

    logic [15:0] exp_q[$];
    logic [2:0]  exp_lvl;
    logic        exp_wide;
    logic [15:0] resp_data;
    int          wait_cnt = 0;

    irq_vector_unit uut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .lvl_sel(lvl_sel),
        .int_en(int_en), .soft_int(soft_int), .berr_flag(berr_flag),
        .berr_int_en(berr_int_en), .vec_rd(vec_rd), .vec_wide(vec_wide),
        .ack_done(ack_done), .ack_data(ack_data), .host_int(host_int),
        .line_active(line_active), .ack_req(ack_req), .ack_addr(ack_addr),
        .ack_wide(ack_wide), .vec_out(vec_out), .rd_done(rd_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still summarizes.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    // Bus-master model: answer a pending acknowledge after three cycles.
    always @(negedge clk) begin
        if (ack_done) begin
            ack_done = 1'b0;
            wait_cnt = 0;
        end else if (ack_req) begin
            wait_cnt++;
            if (wait_cnt == 3) begin
                check(ack_addr == exp_lvl, "R7 ack_addr", ack_addr, exp_lvl);
                check(ack_wide == exp_wide, "R8 ack_wide", ack_wide, exp_wide);
                ack_data = resp_data;
                ack_done = 1'b1;
            end
        end
    end

    // Monitor: pop the expected vector for every completed read.
    always @(negedge clk) begin
        if (rd_done) begin
            done_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 extra rd_done", 1, 0);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                check(vec_out == e, "R8/R11 vec_out", vec_out, e);
            end
        end
    end

    // Driver: issue a read and push the value the requirements predict.
    task automatic do_read(input logic [2:0] lvl, input logic wide, input logic [15:0] data);
        int start;
        exp_lvl   = lvl;
        exp_wide  = wide;
        resp_data = data;
        exp_q.push_back(lvl == 3'd0 ? 16'h0000 : (wide ? data : {8'h00, data[7:0]}));
        lvl_sel  = lvl;
        vec_wide = wide;
        vec_rd   = 1'b1;
        start    = done_seen;
        tick(1);
        vec_rd = 1'b0;
        if (lvl == 3'd0) begin
            // R9: no cycle requested, rd_done already visible
            check(ack_req == 1'b0, "R9 no ack_req", ack_req, 0);
            check(rd_done == 1'b1, "R9 immediate rd_done", rd_done, 1);
        end else begin
            check(ack_req == 1'b1, "R7 ack_req raised", ack_req, 1);
        end
        while (done_seen == start) tick(1);
        tick(1);
        check(rd_done == 1'b0, "R11 single pulse", rd_done, 0);
    endtask

    initial begin
        rst_n = 1'b0; irq_n = 7'h7F; lvl_sel = 3'd0;
        int_en = 0; soft_int = 0; berr_flag = 0; berr_int_en = 0;
        vec_rd = 0; vec_wide = 0; ack_done = 0; ack_data = 16'h0;
        tick(3);
        // R1 reset state
        check(host_int == 0 && ack_req == 0 && rd_done == 0, "R1 outputs", {host_int, ack_req, rd_done}, 0);
        check(vec_out == 16'h0 && ack_addr == 3'd0, "R1 vec/addr", vec_out, 0);
        rst_n = 1'b1;
        tick(1);

        // R3 two-flop latency on level 3
        lvl_sel = 3'd3; irq_n = 7'b1111011;
        tick(1);
        check(line_active == 0, "R3 not after one edge", line_active, 0);
        tick(1);
        check(line_active == 1, "R3 after two edges", line_active, 1);

        // R2 each code watches only its own line
        for (int k = 1; k <= 7; k++) begin
            for (int j = 1; j <= 7; j++) begin
                lvl_sel = 3'(k);
                irq_n = ~(7'd1 << (j - 1));
                tick(3);
                check(line_active == (k == j), "R2 decode", line_active, (k == j));
            end
        end
        irq_n = 7'h00; lvl_sel = 3'd0;
        tick(3);
        check(line_active == 0, "R2 code 0 none", line_active, 0);

        // R4 enable gating
        lvl_sel = 3'd5; int_en = 0;
        tick(2);
        check(host_int == 0, "R4 disabled", host_int, 0);
        int_en = 1;
        tick(1);
        check(host_int == 1, "R4 enabled", host_int, 1);
        irq_n = 7'h7F;
        tick(3);
        check(host_int == 0, "R4 line released", host_int, 0);
        int_en = 0;

        // R5 software interrupt
        soft_int = 1;
        tick(1);
        check(host_int == 1, "R5 soft int", host_int, 1);
        soft_int = 0;
        tick(1);
        check(host_int == 0, "R5 soft int off", host_int, 0);

        // R6 bus-error source
        berr_flag = 1;
        tick(2);
        check(host_int == 0, "R6 berr ignored", host_int, 0);
        berr_int_en = 1;
        tick(1);
        check(host_int == 1, "R6 berr enabled", host_int, 1);
        berr_flag = 0; berr_int_en = 0;
        tick(2);

        // R7 R8 acknowledge reads, wide and narrow
        do_read(3'd4, 1'b1, 16'hA55A);
        do_read(3'd7, 1'b0, 16'hC3E1);
        do_read(3'd1, 1'b1, 16'h1234);
        check(vec_out == 16'h1234, "R11 vec holds", vec_out, 16'h1234);
        // R9 level zero
        do_read(3'd0, 1'b1, 16'hFFFF);

        // R10 changes during a pending cycle are ignored
        exp_lvl = 3'd6; exp_wide = 1'b1; resp_data = 16'hBEEF;
        exp_q.push_back(16'hBEEF);
        lvl_sel = 3'd6; vec_wide = 1'b1; vec_rd = 1'b1;
        tick(1);
        vec_rd = 1'b0; lvl_sel = 3'd2;
        tick(1);
        vec_rd = 1'b1; vec_wide = 1'b0;
        tick(1);
        vec_rd = 1'b0;
        check(ack_addr == 3'd6, "R10 addr latched", ack_addr, 6);
        tick(8);
        check(done_seen == 5, "R10 one completion", done_seen, 5);
        check(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule